// File: doc/BRIEF.md
# Unaligned Vector Load Realigner

This block lets a processor pull a 128-bit vector from any byte address while the memory only serves 16-byte aligned lines. A misaligned-capture load clears the low four bits of the requested address, reads that aligned line and keeps the discarded bits in a 4-bit offset register. The line lands in a small bank of line registers. A plain aligned load fills the bank the same way but leaves the offset alone. Both kinds of load return the pointer advanced by a signed immediate, so software can walk a buffer.

Software issues a capture load and then an aligned load of the next line, and follows them with a merge operation. The merge joins the two stored lines into one 32-byte window, with the first line in the low bytes. It then selects the 16 bytes that start at the recorded offset and presents them as the realigned vector. The offset register can be read at any time and written back from the address field, so a routine can save and restore it.

Top module: `vec_realign_unit`

## Requirements
- R1: After reset, `shift_off` is 0, `vec_valid` is 0, `mem_rd_en` is 0 and every line register holds zero.
- R2: A load operation (`op_code` 0 = capture load, 1 = aligned load) raises `mem_rd_en` in the same cycle. `mem_rd_addr` is then `op_addr` with bits [3:0] cleared.
- R3: A capture load (code 0) sets `shift_off` to `op_addr[3:0]` from the next cycle on.
- R4: During a load, `ptr_next` equals `op_addr` plus `op_inc` sign-extended from 12 bits, modulo 2^32. During any other operation it equals `op_addr`.
- R5: An aligned load (code 1) leaves `shift_off` unchanged.
- R6: The memory answers a read one cycle after the request. That data is written into line `op_dst` of the issuing load at the end of the answer cycle, so a merge may read it from the cycle after.
- R7: A merge (code 2) forms a 32-byte window with line `op_src_a` in bytes 0..15 and line `op_src_b` in bytes 16..31. Byte k of `vec_out` (bits 8k+7..8k) is window byte `shift_off`+k. The result appears in the cycle after the merge, and `vec_valid` is high for exactly that one cycle.
- R8: A merge with `shift_off` equal to 0 returns line `op_src_a` unchanged.
- R9: An offset restore (code 3) sets `shift_off` to `op_addr[3:0]` from the next cycle on.
- R10: Merge and offset-restore operations, and idle cycles, never raise `mem_rd_en`.
- R11: A merge changes neither `shift_off` nor any line register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 2 | 0 capture load, 1 aligned load, 2 merge, 3 offset restore |
| op_dst | input | 3 | Destination line of a load |
| op_src_a | input | 3 | Line placed in the low half of the merge window |
| op_src_b | input | 3 | Line placed in the high half of the merge window |
| op_addr | input | 32 | Byte address of a load, or offset source for a restore |
| op_inc | input | 12 | Signed pointer increment of a load |
| ptr_next | output | 32 | Post-incremented pointer |
| mem_rd_en | output | 1 | Aligned line read request |
| mem_rd_addr | output | 32 | Aligned line address |
| mem_rd_data | input | 128 | Line returned one cycle after the request |
| vec_out | output | 128 | Realigned vector from the last merge |
| vec_valid | output | 1 | `vec_out` was produced by the merge of the previous cycle |
| shift_off | output | 4 | Current byte offset register |

## Verification
Some rules are checked on every cycle: read addresses are always line-aligned, reads happen only for load codes, the offset is captured by capture loads and restores and holds across aligned loads, `vec_valid` only follows a merge, and a zero offset passes the low line through. Other results can only be shown by the bench's scenarios, because they need a byte-level model of memory. These are the correct byte selection for all sixteen offsets, the effect of swapping the two merge sources, pointer arithmetic with negative and large increments, and the one-cycle write-back timing of load data into the line bank.

// File: rtl/vr_pkg.sv
package vr_pkg;

  typedef enum logic [1:0] {
    OP_ULOAD   = 2'd0,
    OP_ALOAD   = 2'd1,
    OP_COMBINE = 2'd2,
    OP_SETOFF  = 2'd3
  } vr_op_e;

endpackage

// File: rtl/vr_addr_gen.sv
module vr_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int INC_W  = 12,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [INC_W-1:0]  inc,
  input  logic              is_load,
  output logic [ADDR_W-1:0] aligned,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [OFF_W-1:0]  off_field
);

  function automatic logic [ADDR_W-1:0] clear_low(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] add_signed(input logic [ADDR_W-1:0] a,
                                                   input logic [INC_W-1:0]  d);
    return a + {{(ADDR_W-INC_W){d[INC_W-1]}}, d};
  endfunction

  assign aligned   = clear_low(addr);
  assign off_field = addr[OFF_W-1:0];
  assign next_ptr  = is_load ? add_signed(addr, inc) : addr;

endmodule

// File: rtl/vr_line_bank.sv
module vr_line_bank #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 128,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [VEC_W-1:0] rd_a,
  output logic [VEC_W-1:0] rd_b
);

  localparam int FLAT_W = NUM_LINES * VEC_W;

  logic [FLAT_W-1:0] flat;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [VEC_W-1:0] q;
    logic             hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign flat[g*VEC_W +: VEC_W] = q;
  end

  assign rd_a = flat[rd_idx_a*VEC_W +: VEC_W];
  assign rd_b = flat[rd_idx_b*VEC_W +: VEC_W];

endmodule

// File: rtl/vr_funnel.sv
module vr_funnel #(
  parameter int VEC_BYTES = 16,
  parameter int OFF_W     = 4
) (
  input  logic [VEC_BYTES*8-1:0] lo,
  input  logic [VEC_BYTES*8-1:0] hi,
  input  logic [OFF_W-1:0]       off,
  output logic [VEC_BYTES*8-1:0] out
);

  localparam int VEC_W = VEC_BYTES * 8;
  localparam int SEL_W = OFF_W + 1;

  logic [2*VEC_W-1:0] window;
  assign window = {hi, lo};

  function automatic logic [7:0] pick_byte(input logic [2*VEC_W-1:0] w,
                                           input logic [SEL_W-1:0]   s);
    return w[s*8 +: 8];
  endfunction

  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_byte
    logic [SEL_W-1:0] sel;
    assign sel = SEL_W'(g) + {1'b0, off};
    assign out[g*8 +: 8] = pick_byte(window, sel);
  end

endmodule

// File: rtl/vec_realign_unit.sv
module vec_realign_unit
  import vr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int INC_W     = 12,
  parameter int VEC_BYTES = 16,
  parameter int NUM_LINES = 8,
  localparam int VEC_W    = VEC_BYTES * 8,
  localparam int OFF_W    = $clog2(VEC_BYTES),
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [IDX_W-1:0]  op_dst,
  input  logic [IDX_W-1:0]  op_src_a,
  input  logic [IDX_W-1:0]  op_src_b,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [INC_W-1:0]  op_inc,
  output logic [ADDR_W-1:0] ptr_next,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [VEC_W-1:0]  mem_rd_data,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid,
  output logic [OFF_W-1:0]  shift_off
);

  vr_op_e op;
  assign op = vr_op_e'(op_code);

  // named events for the checker
  logic uload_fire, aload_fire, combine_fire, setoff_fire, load_fire;
  assign uload_fire   = op_valid && (op == OP_ULOAD);
  assign aload_fire   = op_valid && (op == OP_ALOAD);
  assign combine_fire = op_valid && (op == OP_COMBINE);
  assign setoff_fire  = op_valid && (op == OP_SETOFF);
  assign load_fire    = uload_fire || aload_fire;

  logic [ADDR_W-1:0] aligned_addr;
  logic [ADDR_W-1:0] next_ptr_w;
  logic [OFF_W-1:0]  addr_off;

  vr_addr_gen #(.ADDR_W(ADDR_W), .INC_W(INC_W), .OFF_W(OFF_W)) u_addr (
    .addr      (op_addr),
    .inc       (op_inc),
    .is_load   (load_fire),
    .aligned   (aligned_addr),
    .next_ptr  (next_ptr_w),
    .off_field (addr_off)
  );

  assign mem_rd_en   = load_fire;
  assign mem_rd_addr = aligned_addr;
  assign ptr_next    = next_ptr_w;

  // byte offset register
  logic [OFF_W-1:0] shift_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                          shift_q <= '0;
    else if (uload_fire || setoff_fire)  shift_q <= addr_off;
  end
  assign shift_off = shift_q;

  // pending load write-back
  logic             ld_pend_q;
  logic [IDX_W-1:0] ld_dst_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend_q <= 1'b0;
      ld_dst_q  <= '0;
    end else begin
      ld_pend_q <= load_fire;
      if (load_fire) ld_dst_q <= op_dst;
    end
  end

  logic [VEC_W-1:0] line_a_rd, line_b_rd;

  vr_line_bank #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_pend_q),
    .wr_idx   (ld_dst_q),
    .wr_data  (mem_rd_data),
    .rd_idx_a (op_src_a),
    .rd_idx_b (op_src_b),
    .rd_a     (line_a_rd),
    .rd_b     (line_b_rd)
  );

  logic [VEC_W-1:0] funnel_w;

  vr_funnel #(.VEC_BYTES(VEC_BYTES), .OFF_W(OFF_W)) u_funnel (
    .lo  (line_a_rd),
    .hi  (line_b_rd),
    .off (shift_q),
    .out (funnel_w)
  );

  logic [VEC_W-1:0] vec_q;
  logic             vec_valid_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      vec_valid_q <= combine_fire;
      if (combine_fire) vec_q <= funnel_w;
    end
  end

  assign vec_out   = vec_q;
  assign vec_valid = vec_valid_q;

endmodule

// File: rtl/vr_checker.sv
module vr_checker #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 128,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_code,
  input logic [OFF_W-1:0]  op_addr_low,
  input logic              mem_rd_en,
  input logic [OFF_W-1:0]  mem_rd_addr_low,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_out,
  input logic [OFF_W-1:0]  shift_off,
  input logic              combine_fire,
  input logic [VEC_W-1:0]  line_a_rd
);

  p_rd_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr_low == '0));

  p_rd_only_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (op_valid && !op_code[1]));

  p_off_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd0) |=> (shift_off == $past(op_addr_low)));

  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd1) |=> $stable(shift_off));

  p_off_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd3) |=> (shift_off == $past(op_addr_low)));

  p_vec_after_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(combine_fire));

  p_zero_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (combine_fire && shift_off == '0) |=> (vec_out == $past(line_a_rd)));

  p_merge_keeps_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd2) |=> $stable(shift_off));

endmodule

bind vec_realign_unit vr_checker #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .OFF_W(OFF_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .op_valid        (op_valid),
  .op_code         (op_code),
  .op_addr_low     (op_addr[OFF_W-1:0]),
  .mem_rd_en       (mem_rd_en),
  .mem_rd_addr_low (mem_rd_addr[OFF_W-1:0]),
  .vec_valid       (vec_valid),
  .vec_out         (vec_out),
  .shift_off       (shift_off),
  .combine_fire    (combine_fire),
  .line_a_rd       (line_a_rd)
);

// File: tb/test_vec_realign_unit.sv
`timescale 1ns/1ps
module test_vec_realign_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [1:0]   op_code = 2'd0;
  logic [2:0]   op_dst = 3'd0;
  logic [2:0]   op_src_a = 3'd0;
  logic [2:0]   op_src_b = 3'd0;
  logic [31:0]  op_addr = 32'd0;
  logic [11:0]  op_inc = 12'd0;
  logic [31:0]  ptr_next;
  logic         mem_rd_en;
  logic [31:0]  mem_rd_addr;
  logic [127:0] mem_rd_data = '0;
  logic [127:0] vec_out;
  logic         vec_valid;
  logic [3:0]   shift_off;

  always #2 clk = ~clk;

  vec_realign_unit i_vec_realign_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
    .op_addr(op_addr), .op_inc(op_inc), .ptr_next(ptr_next),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .vec_out(vec_out), .vec_valid(vec_valid), .shift_off(shift_off)
  );

  // byte memory model with one-cycle read latency
  logic [7:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) & 255);

  always @(posedge clk) begin
    if (mem_rd_en)
      for (int b = 0; b < 16; b++)
        mem_rd_data[b*8 +: 8] <= mem[(int'(mem_rd_addr[5:0]) + b) & 63];
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] bytes_from(input int base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = mem[(base + k) & 63];
    return v;
  endfunction

  task automatic issue(input logic [1:0] code, input logic [2:0] dst,
                       input logic [2:0] sa, input logic [2:0] sb,
                       input logic [31:0] addr, input logic [11:0] inc);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_dst = dst;
    op_src_a = sa; op_src_b = sb; op_addr = addr; op_inc = inc;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  // addr, inc, expected ptr_next
  localparam logic [75:0] VEC_TAB [16] = '{
    {32'd0,  12'd16,  32'd16},
    {32'd17, 12'd16,  32'd33},
    {32'd2,  12'd16,  32'd18},
    {32'd19, 12'd16,  32'd35},
    {32'd4,  12'd16,  32'd20},
    {32'd21, 12'd16,  32'd37},
    {32'd6,  12'd16,  32'd22},
    {32'd23, 12'd16,  32'd39},
    {32'd8,  12'd16,  32'd24},
    {32'd25, 12'd16,  32'd41},
    {32'd10, 12'd16,  32'd26},
    {32'd27, 12'd16,  32'd43},
    {32'd12, 12'hFF0, 32'hFFFF_FFFC},
    {32'd29, 12'd0,   32'd29},
    {32'd14, 12'd32,  32'd46},
    {32'd31, 12'h7FF, 32'd2078}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 shift_off", 128'(shift_off), 128'd0);
    chk("R1 vec_valid", 128'(vec_valid), 128'd0);
    chk("R1 mem_rd_en", 128'(mem_rd_en), 128'd0);
    issue(2'd2, 3'd0, 3'd0, 3'd1, 32'd0, 12'd0);
    idle();
    chk("R1 lines zero", vec_out, 128'd0);

    for (int k = 0; k < 16; k++) begin
      logic [31:0] a, inc, pexp, al;
      logic [2:0]  da;
      {a, inc[11:0], pexp} = VEC_TAB[k];
      al = a & ~32'hF;
      da = 3'((k % 4) * 2);
      issue(2'd0, da, 3'd0, 3'd0, a, inc[11:0]);
      chk("R2 rd_en", 128'(mem_rd_en), 128'd1);
      chk("R2 rd_addr", 128'(mem_rd_addr), 128'(al));
      chk("R4 ptr_next", 128'(ptr_next), 128'(pexp));
      issue(2'd1, da + 3'd1, 3'd0, 3'd0, al + 32'd16, 12'd16);
      chk("R3 offset captured", 128'(shift_off), 128'(a[3:0]));
      chk("R2 aligned rd_addr", 128'(mem_rd_addr), 128'(al + 32'd16));
      idle();
      issue(2'd2, 3'd0, da, da + 3'd1, 32'd0, 12'd0);
      chk("R10 no read on merge", 128'(mem_rd_en), 128'd0);
      chk("R4 ptr_next non-load", 128'(ptr_next), 128'd0);
      chk("R5 offset held", 128'(shift_off), 128'(a[3:0]));
      idle();
      chk("R7 vec_valid", 128'(vec_valid), 128'd1);
      chk("R7 R6 realigned vector", vec_out, bytes_from(int'(a)));
      chk("R11 offset after merge", 128'(shift_off), 128'(a[3:0]));
    end

    // lines 6/7 now hold mem[16..31] and mem[32..47]
    issue(2'd3, 3'd0, 3'd0, 3'd0, 32'h0000_0030, 12'd5);
    chk("R10 no read on restore", 128'(mem_rd_en), 128'd0);
    idle();
    chk("R9 restore zero", 128'(shift_off), 128'd0);
    issue(2'd2, 3'd0, 3'd6, 3'd7, 32'd0, 12'd0);
    idle();
    chk("R8 zero offset passthrough", vec_out, bytes_from(16));
    idle();
    chk("R7 vec_valid single pulse", 128'(vec_valid), 128'd0);

    issue(2'd3, 3'd0, 3'd0, 3'd0, 32'h1234_567F, 12'd0);
    idle();
    chk("R9 restore fifteen", 128'(shift_off), 128'd15);
    issue(2'd2, 3'd0, 3'd7, 3'd6, 32'd0, 12'd0);
    idle();
    begin
      logic [127:0] e;
      e[7:0] = mem[47];
      for (int k = 1; k < 16; k++) e[k*8 +: 8] = mem[16 + k - 1];
      chk("R7 swapped sources", vec_out, e);
    end
    chk("R11 lines unchanged", 128'(shift_off), 128'd15);
    issue(2'd2, 3'd0, 3'd6, 3'd7, 32'd0, 12'd0);
    idle();
    chk("R11 line reread", vec_out, bytes_from(31));

    // R5: aligned load after a capture keeps the offset
    issue(2'd0, 3'd2, 3'd0, 3'd0, 32'd9, 12'd16);
    issue(2'd1, 3'd3, 3'd0, 3'd0, 32'd37, 12'd16);
    chk("R2 aligned load clears low bits", 128'(mem_rd_addr), 128'd32);
    idle();
    chk("R5 aligned load keeps offset", 128'(shift_off), 128'd9);
    issue(2'd2, 3'd0, 3'd2, 3'd3, 32'd0, 12'd0);
    idle();
    begin
      logic [127:0] e;
      for (int k = 0; k < 7; k++)  e[k*8 +: 8] = mem[9 + k];
      for (int k = 7; k < 16; k++) e[k*8 +: 8] = mem[32 + k - 7];
      chk("R6 R7 non-adjacent lines", vec_out, e);
    end
    idle();
    finish_run();
  end

endmodule